// File: doc/BRIEF.md
# Dual-Loop Serial Control Register Loader

This block is the programming front end of a two-loop frequency synthesizer. A host writes 24-bit control words over three wires: a serial clock, a data line and a latch enable. Bits enter a shift register most significant bit first. When the latch enable rises, the two lowest bits of the shifted word select the destination. The whole word is then copied into either the main-loop (RF) divider register or the auxiliary-loop (IF) divider register. Any other selection leaves both registers as they were.

From the two registers the block derives these control outputs for each loop:
- a power-down,
- a counter reset,
- a prescaler range select (main loop only).

Power-down can be entered in two ways. In immediate style the loop goes down as soon as its request bit is latched. In gated style the request waits until the loop reports that its current charge-pump pulse has finished. One bit in the IF register picks the style for both loops. The serial path runs on the system clock through synchronisers, so it keeps loading during every power-down state.

The three serial wires are asynchronous level inputs. They carry no handshake and cannot be back-pressured. The host must hold each data bit stable for at least two system clocks before and after each rising serial clock edge, and must hold every level for at least three system clocks.

Top module: `ser_pll_loader`

## Requirements
- R1: After reset, both register outputs, both power-down outputs, both counter-reset outputs and the prescaler output are 0. Power-down style is immediate.
- R2: The 24 bits shifted in before a latch-enable rise are taken most significant bit first. If word bits [1:0] are 2'b11, the whole word appears on `rf_nreg`.
- R3: If word bits [1:0] are 2'b10, the whole word appears on `if_nreg`.
- R4: If word bits [1:0] are 2'b00 or 2'b01, neither `rf_nreg` nor `if_nreg` changes.
- R5: Bit 23 of each loop register drives that loop's counter-reset output. Bit 21 of the RF register drives `rf_presc_hi`.
- R6: With IF bit 21 at 0 (immediate style), a loop whose register bit 22 is 1 shows power-down on the clock after the register took that value.
- R7: With IF bit 21 at 1 (gated style), a newly requested power-down stays low until that loop's `*_cp_done` strobe is high for one clock. Power-down is then high on the next clock.
- R8: A register bit 22 of 0 releases that loop's power-down, or cancels a waiting request, on the next clock. A later strobe does not bring the loop down.
- R9: Words load and latch normally while either or both loops are powered down.
- R10: IF bit 21 sets the power-down style of the RF loop as well as the IF loop. Switching to immediate style brings down a loop whose request is waiting.
- R11: When more than 24 bits are shifted before a latch, only the last 24 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous; shifts on rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Latch enable, asynchronous; transfers on rising edge |
| rf_cp_done | input | 1 | One-clock strobe: main-loop charge-pump pulse finished |
| if_cp_done | input | 1 | One-clock strobe: auxiliary-loop charge-pump pulse finished |
| rf_nreg | output | 24 | Main-loop register contents |
| if_nreg | output | 24 | Auxiliary-loop register contents |
| rf_pwdn | output | 1 | Main loop powered down |
| if_pwdn | output | 1 | Auxiliary loop powered down |
| rf_cnt_rst | output | 1 | Main-loop counter reset |
| if_cnt_rst | output | 1 | Auxiliary-loop counter reset |
| rf_presc_hi | output | 1 | Main-loop high prescaler range selected |

## Verification
Each serial edge passes two synchroniser flops and one edge register. A latch-enable rise therefore reaches `rf_nreg`/`if_nreg` and the counter-reset and prescaler outputs on the third rising clock after it. Immediate-style power-down follows one clock later. A `*_cp_done` strobe shows on the power-down output at the first rising edge that samples it.

The bench drives and samples on falling edges. After each latch it waits six clocks before comparing every output with a bench model. After each strobe it waits two clocks. It also samples a waiting loop many clocks after its request, to show that power-down has not yet appeared.

// File: rtl/sl_pkg.sv
package sl_pkg;
  localparam int CTL_W        = 2;
  localparam int NUM_LOOPS    = 2;
  localparam int LOOP_RF      = 0;
  localparam int LOOP_IF      = 1;
  localparam int BIT_CNT_RST  = 23;
  localparam int BIT_PWDN     = 22;
  localparam int BIT_SEL      = 21;  // IF: gated-style select, RF: prescaler range
  localparam logic [CTL_W-1:0] ADDR_RF = 2'b11;
  localparam logic [CTL_W-1:0] ADDR_IF = 2'b10;

  typedef enum logic [1:0] {
    PD_UP   = 2'd0,
    PD_WAIT = 2'd1,
    PD_DOWN = 2'd2
  } pd_state_e;

  function automatic logic [CTL_W-1:0] loop_addr(input int idx);
    return (idx == LOOP_RF) ? ADDR_RF : ADDR_IF;
  endfunction
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= d;
      end
      assign q = stg;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stg;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[STAGES-2:0], d};
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sl_frontend.sv
module sl_frontend #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic ser_le,
  output logic shift_stb,
  output logic shift_bit,
  output logic latch_stb
);
  localparam int LINES = 3;
  localparam int IDX_CLK = 0;
  localparam int IDX_DAT = 1;
  localparam int IDX_LE  = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic             clk_prev;
  logic             le_prev;

  assign raw[IDX_CLK] = ser_clk;
  assign raw[IDX_DAT] = ser_data;
  assign raw[IDX_LE]  = ser_le;

  sl_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw),
    .q    (synced)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev <= 1'b0;
      le_prev  <= 1'b0;
    end else begin
      clk_prev <= synced[IDX_CLK];
      le_prev  <= synced[IDX_LE];
    end
  end

  assign shift_stb = synced[IDX_CLK] & ~clk_prev;
  assign shift_bit = synced[IDX_DAT];
  assign latch_stb = synced[IDX_LE] & ~le_prev;
endmodule

// File: rtl/sl_regfile.sv
module sl_regfile
  import sl_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               shift_stb,
  input  logic                               shift_bit,
  input  logic                               latch_stb,
  output logic [NUM_LOOPS-1:0][WORD_W-1:0]   nreg
);
  logic [WORD_W-1:0] shreg;
  logic [CTL_W-1:0]  sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         shreg <= '0;
    else if (shift_stb) shreg <= {shreg[WORD_W-2:0], shift_bit};
  end

  assign sel = shreg[CTL_W-1:0];

  generate
    for (genvar l = 0; l < NUM_LOOPS; l++) begin : g_loop
      localparam logic [CTL_W-1:0] MY_ADDR = loop_addr(l);
      logic hit;
      assign hit = latch_stb && (sel == MY_ADDR);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   nreg[l] <= '0;
        else if (hit) nreg[l] <= shreg;
      end
    end
  endgenerate
endmodule

// File: rtl/sl_pd_seq.sv
module sl_pd_seq
  import sl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic gated,
  input  logic cp_done,
  output logic pwdn
);
  pd_state_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      PD_UP: begin
        if (req) nxt = gated ? PD_WAIT : PD_DOWN;
      end
      PD_WAIT: begin
        if (!req)                   nxt = PD_UP;
        else if (!gated || cp_done) nxt = PD_DOWN;
      end
      PD_DOWN: begin
        if (!req) nxt = PD_UP;
      end
      default: nxt = PD_UP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PD_UP;
    else        state <= nxt;
  end

  assign pwdn = (state == PD_DOWN);
endmodule

// File: rtl/ser_pll_loader.sv
module ser_pll_loader
  import sl_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  input  logic              ser_le,
  input  logic              rf_cp_done,
  input  logic              if_cp_done,
  output logic [WORD_W-1:0] rf_nreg,
  output logic [WORD_W-1:0] if_nreg,
  output logic              rf_pwdn,
  output logic              if_pwdn,
  output logic              rf_cnt_rst,
  output logic              if_cnt_rst,
  output logic              rf_presc_hi
);
  logic                             shift_stb;
  logic                             shift_bit;
  logic                             latch_stb;
  logic [NUM_LOOPS-1:0][WORD_W-1:0] nreg;
  logic [NUM_LOOPS-1:0]             done_v;
  logic [NUM_LOOPS-1:0]             pwdn_v;
  logic                             gated;

  sl_frontend #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_clk  (ser_clk),
    .ser_data (ser_data),
    .ser_le   (ser_le),
    .shift_stb(shift_stb),
    .shift_bit(shift_bit),
    .latch_stb(latch_stb)
  );

  sl_regfile #(.WORD_W(WORD_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_stb(shift_stb),
    .shift_bit(shift_bit),
    .latch_stb(latch_stb),
    .nreg     (nreg)
  );

  assign gated           = nreg[LOOP_IF][BIT_SEL];
  assign done_v[LOOP_RF] = rf_cp_done;
  assign done_v[LOOP_IF] = if_cp_done;

  generate
    for (genvar l = 0; l < NUM_LOOPS; l++) begin : g_pd
      sl_pd_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (nreg[l][BIT_PWDN]),
        .gated  (gated),
        .cp_done(done_v[l]),
        .pwdn   (pwdn_v[l])
      );
    end
  endgenerate

  assign rf_nreg     = nreg[LOOP_RF];
  assign if_nreg     = nreg[LOOP_IF];
  assign rf_pwdn     = pwdn_v[LOOP_RF];
  assign if_pwdn     = pwdn_v[LOOP_IF];
  assign rf_cnt_rst  = nreg[LOOP_RF][BIT_CNT_RST];
  assign if_cnt_rst  = nreg[LOOP_IF][BIT_CNT_RST];
  assign rf_presc_hi = nreg[LOOP_RF][BIT_SEL];
endmodule

// File: rtl/sl_chk.sv
module sl_chk #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rf_cp_done,
  input logic              if_cp_done,
  input logic [WORD_W-1:0] rf_nreg,
  input logic [WORD_W-1:0] if_nreg,
  input logic              rf_pwdn,
  input logic              if_pwdn
);
  // Immediate style: a standing request forces power-down next clock
  assert_rf_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_nreg[21] && rf_nreg[22]) |=> rf_pwdn);
  assert_if_immediate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_nreg[21] && if_nreg[22]) |=> if_pwdn);

  // Gated style: entry only after a strobe
  assert_rf_gated_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rf_pwdn) |-> ($past(rf_cp_done) || !$past(if_nreg[21])));
  assert_if_gated_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(if_pwdn) |-> ($past(if_cp_done) || !$past(if_nreg[21])));

  // Cleared request releases on the next clock
  assert_rf_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_nreg[22] |=> !rf_pwdn);
  assert_if_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !if_nreg[22] |=> !if_pwdn);
endmodule

bind ser_pll_loader sl_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rf_cp_done(rf_cp_done),
  .if_cp_done(if_cp_done),
  .rf_nreg   (rf_nreg),
  .if_nreg   (if_nreg),
  .rf_pwdn   (rf_pwdn),
  .if_pwdn   (if_pwdn)
);

// File: tb/sim_ser_pll_loader.sv
`timescale 1ns/1ps
module sim_ser_pll_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
  logic        rf_cp_done = 1'b0, if_cp_done = 1'b0;
  logic [23:0] rf_nreg, if_nreg;
  logic        rf_pwdn, if_pwdn, rf_cnt_rst, if_cnt_rst, rf_presc_hi;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // bench model
  logic [23:0] m_rf = '0, m_if = '0;
  int          m_st [2] = '{0, 0};   // 0 up, 1 waiting, 2 down

  always #2.5 clk = ~clk;

  ser_pll_loader u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .rf_cp_done(rf_cp_done), .if_cp_done(if_cp_done),
    .rf_nreg(rf_nreg), .if_nreg(if_nreg), .rf_pwdn(rf_pwdn), .if_pwdn(if_pwdn),
    .rf_cnt_rst(rf_cnt_rst), .if_cnt_rst(if_cnt_rst), .rf_presc_hi(rf_presc_hi)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] mk(logic cr, logic pd, logic sel,
                                     logic [18:0] body, logic [1:0] ctl);
    return {cr, pd, sel, body, ctl};
  endfunction

  function automatic int step_state(int st, logic req, logic gated);
    if (!req) return 0;
    if (st == 0) return gated ? 1 : 2;
    if (st == 1 && !gated) return 2;
    return st;
  endfunction

  task automatic model_latch(logic [23:0] w);
    if (w[1:0] == 2'b11) m_rf = w;
    else if (w[1:0] == 2'b10) m_if = w;
    m_st[0] = step_state(m_st[0], m_rf[22], m_if[21]);
    m_st[1] = step_state(m_st[1], m_if[22], m_if[21]);
  endtask

  task automatic check_all(string tag);
    cmp({tag, " rf_nreg"}, {8'h0, rf_nreg}, {8'h0, m_rf});
    cmp({tag, " if_nreg"}, {8'h0, if_nreg}, {8'h0, m_if});
    cmp({tag, " rf_pwdn R6/R7/R8"}, {31'h0, rf_pwdn}, {31'h0, m_st[0] == 2});
    cmp({tag, " if_pwdn R6/R7/R8"}, {31'h0, if_pwdn}, {31'h0, m_st[1] == 2});
    cmp({tag, " cnt_rst R5"}, {30'h0, rf_cnt_rst, if_cnt_rst}, {30'h0, m_rf[23], m_if[23]});
    cmp({tag, " presc R5"}, {31'h0, rf_presc_hi}, {31'h0, m_rf[21]});
  endtask

  task automatic send_bit(logic b);
    ser_data = b;
    tick(3);
    ser_clk = 1'b1;
    tick(3);
    ser_clk = 1'b0;
    tick(2);
  endtask

  // shift w (MSB first) after 'extra' leading junk bits, then latch
  task automatic load(logic [23:0] w, int extra);
    for (int i = 0; i < extra; i++) send_bit(1'($urandom));
    for (int i = 23; i >= 0; i--) send_bit(w[i]);
    ser_le = 1'b1;
    tick(3);
    ser_le = 1'b0;
    tick(6);
    model_latch(w);
  endtask

  task automatic strobe(int loop);
    if (loop == 0) rf_cp_done = 1'b1; else if_cp_done = 1'b1;
    tick(1);
    rf_cp_done = 1'b0;
    if_cp_done = 1'b0;
    tick(2);
    if (m_st[loop] == 1 && m_if[21]) m_st[loop] = 2;
  endtask

  initial begin
    void'($urandom(32'd2024));
    tick(4);
    rst_n = 1'b1;
    tick(2);
    check_all("R1 reset");

    // R2: RF word
    load(mk(1'b0, 1'b0, 1'b1, 19'h5a5a5, 2'b11), 0);
    check_all("R2 rf load");
    cmp("R2 rf word", {8'h0, rf_nreg}, {8'h0, 24'h3696_97});
    // R3: IF word
    load(mk(1'b1, 1'b0, 1'b0, 19'h12345, 2'b10), 0);
    check_all("R3 if load");
    // R4: other codes ignored
    load(mk(1'b1, 1'b1, 1'b1, 19'h7ffff, 2'b00), 0);
    check_all("R4 code 00");
    load(mk(1'b1, 1'b1, 1'b1, 19'h00001, 2'b01), 0);
    check_all("R4 code 01");
    // R5 counter reset / prescaler
    load(mk(1'b1, 1'b0, 1'b1, 19'h0, 2'b11), 0);
    check_all("R5 rf cnt_rst presc");
    // R6: immediate power-down on RF
    load(mk(1'b0, 1'b0, 1'b0, 19'h0, 2'b10), 0);
    load(mk(1'b0, 1'b1, 1'b0, 19'h1, 2'b11), 0);
    check_all("R6 immediate");
    cmp("R6 rf_pwdn", {31'h0, rf_pwdn}, 32'h1);
    // R9: loading while powered down
    load(mk(1'b1, 1'b1, 1'b1, 19'h2aaaa, 2'b11), 0);
    check_all("R9 load while down");
    // R8 release
    load(mk(1'b0, 1'b0, 1'b0, 19'h3, 2'b11), 0);
    check_all("R8 release");
    // R7: gated IF power-down waits for strobe
    load(mk(1'b0, 1'b1, 1'b1, 19'h4, 2'b10), 0);
    tick(20);
    check_all("R7 waiting");
    cmp("R7 if_pwdn low while waiting", {31'h0, if_pwdn}, 32'h0);
    strobe(0);   // wrong loop: no effect
    check_all("R7 other strobe");
    strobe(1);
    check_all("R7 after strobe");
    cmp("R7 if_pwdn", {31'h0, if_pwdn}, 32'h1);
    // R8: cancel waiting RF request
    load(mk(1'b0, 1'b1, 1'b0, 19'h5, 2'b11), 0);
    load(mk(1'b0, 1'b0, 1'b0, 19'h6, 2'b11), 0);
    strobe(0);
    check_all("R8 cancel");
    cmp("R8 rf_pwdn after cancel", {31'h0, rf_pwdn}, 32'h0);
    // R10: waiting RF goes down when IF switches to immediate
    load(mk(1'b0, 1'b1, 1'b0, 19'h7, 2'b11), 0);
    check_all("R10 rf waiting");
    load(mk(1'b0, 1'b1, 1'b0, 19'h8, 2'b10), 0);
    check_all("R10 switch immediate");
    cmp("R10 rf_pwdn", {31'h0, rf_pwdn}, 32'h1);
    // R11: extra leading bits discarded
    load(mk(1'b1, 1'b0, 1'b1, 19'h6b6b6, 2'b10), 9);
    check_all("R11 long shift");

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [23:0] w;
      w = 24'($urandom);
      load(w, int'($urandom_range(0, 3)));
      check_all("R2/R3/R4/R9 random");
      if ($urandom_range(0, 2) == 0) begin
        strobe(int'($urandom_range(0, 1)));
        check_all("R7 random strobe");
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule